// File: doc/BRIEF.md
# Card Bus Clock Generator

This block derives the serial clock for a memory-card bus from a fast reference clock. The ratio is the product of two programmable factors: an even prescale divisor and a second stage that divides by one plus a rate value. The resulting bus clock period is `DIVIDE * (1 + RATE)` reference cycles, with equal high and low phases. The fastest setting gives half the reference frequency.

The clock runs while a transfer asks for it (`run_req`) or while free-running mode is enabled (`cont_clk_en`). Free-running mode is used at card power-up, when the card needs a long train of clock cycles before the first command. When neither is active the clock rests low. Two single-cycle strobes mark the rising and falling transitions so that neighbouring command and data shifters can act on them.

The divisor register also holds a timeout limit. This block stores the limit and passes it on to the data path.

The control logic is a three-state machine:
- `CK_IDLE`: clock low, counters cleared, the divisor copied from the written value on every cycle.
- `CK_HIGH`: clock high.
- `CK_LOW`: clock low, running.

The transitions are:
- `IDLE->HIGH` when a request or free-running mode is present.
- `HIGH->LOW` at the end of a half period. The newly written divisor is adopted here.
- `LOW->HIGH` at the end of a half period while still requested.
- `LOW->IDLE` at the end of a half period with no request.

Top module: `card_clk_divider`

## Requirements
- R1: While reset is held and directly after it, `sclk_o`, `rise_stb_o` and `fall_stb_o` are 0 and `tmo_limit_o` is all ones.
- R2: While running, `sclk_o` stays high for `(D/2)*(1+RATE)` reference cycles and low for the same count, where D is the legal divisor.
- R3: With DIVIDE=2 and RATE=0, `sclk_o` alternates level on every reference cycle.
- R4: An odd written DIVIDE acts as DIVIDE-1, and a written DIVIDE of 0 or 1 acts as 2.
- R5: With `cont_clk_en`=1 and `run_req`=0 the clock runs, giving at least 74 rising edges in 160 reference cycles at DIVIDE=2, RATE=0.
- R6: With `run_req`=0 and `cont_clk_en`=0 in the idle state, `sclk_o` and both strobes stay 0.
- R7: From idle, `sclk_o` and `rise_stb_o` are 1 in the first cycle after the cycle in which a request is first sampled.
- R8: Dropping the request during a high phase does not shorten it. The high phase and one full low phase complete, and then the clock stays low.
- R9: A divisor written during a high phase leaves that high phase at its old length. It governs every phase from the following low phase on.
- R10: `rise_stb_o` is 1 only in the first cycle in which `sclk_o` is 1 after being 0. `fall_stb_o` is 1 only in the first cycle in which `sclk_o` is 0 after being 1.
- R11: The timeout field written with `cfg_we` appears on `tmo_limit_o` from the next cycle on, whatever the clock state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Write strobe for the divisor register |
| cfg_divide | input | DIV_W | Prescale divisor, even 2..254 after legalisation |
| cfg_rate | input | RATE_W | Rate value; the second stage divides by 1+rate |
| cfg_timeout | input | TMO_W | Timeout limit stored with the divisor |
| run_req | input | 1 | A transfer requests the bus clock |
| cont_clk_en | input | 1 | Free-running clock mode for power-up |
| sclk_o | output | 1 | Card bus clock |
| rise_stb_o | output | 1 | One-cycle strobe on the rising transition |
| fall_stb_o | output | 1 | One-cycle strobe on the falling transition |
| tmo_limit_o | output | TMO_W | Stored timeout limit |

## Verification
The bench walks a table of divisor pairs that includes the fastest setting, odd values, and 0 and 1 as divisors. A design that rounded an odd divisor up, or let a zero through, would show wrong phase lengths or stop toggling. It drops the request partway through a high phase; a design that stopped at once would emit a runt pulse shorter than the programmed half period. It rewrites the divisor during a high phase and expects the old length for the rest of that phase and the new length from the next low phase. A design that adopted the divisor at once would cut or stretch the pulse already on the wire. The bench also checks the strobes against the observed clock levels and confirms that the first rising edge follows a request by one cycle.

// File: rtl/card_clk_pkg.sv
package card_clk_pkg;

    typedef enum logic [1:0] {
        CK_IDLE = 2'd0,
        CK_HIGH = 2'd1,
        CK_LOW  = 2'd2
    } ck_state_e;

endpackage

// File: rtl/clkdiv_cfg.sv
module clkdiv_cfg #(
    parameter int DIV_W  = 8,
    parameter int RATE_W = 8,
    parameter int TMO_W  = 16,
    localparam int HALF_W = DIV_W - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DIV_W-1:0]  wr_div,
    input  logic [RATE_W-1:0] wr_rate,
    input  logic [TMO_W-1:0]  wr_tmo,
    input  logic              load,
    output logic [HALF_W-1:0] act_half,
    output logic [RATE_W-1:0] act_rate,
    output logic [TMO_W-1:0]  tmo_limit
);

    logic [HALF_W-1:0] raw_half;
    logic [HALF_W-1:0] legal_half;
    logic [HALF_W-1:0] pend_half;
    logic [RATE_W-1:0] pend_rate;

    // Halving drops bit 0, so odd values round down; a zero half becomes one.
    always_comb begin
        raw_half   = HALF_W'(wr_div >> 1);
        legal_half = (raw_half == '0) ? HALF_W'(1) : raw_half;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_half <= HALF_W'(1);
            pend_rate <= '0;
            tmo_limit <= '1;
        end else if (wr_en) begin
            pend_half <= legal_half;
            pend_rate <= wr_rate;
            tmo_limit <= wr_tmo;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_half <= HALF_W'(1);
            act_rate <= '0;
        end else if (load) begin
            act_half <= pend_half;
            act_rate <= pend_rate;
        end
    end

    a_r4_half_legal: assert property (@(posedge clk) disable iff (!rst_n)
        act_half != '0);

endmodule

// File: rtl/clkdiv_phase.sv
module clkdiv_phase #(
    parameter int HALF_W = 7,
    parameter int RATE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [HALF_W-1:0] half,
    input  logic [RATE_W-1:0] rate,
    output logic              phase_end
);

    logic [HALF_W-1:0] pre_cnt;
    logic [RATE_W-1:0] rate_cnt;
    logic              pre_last;

    always_comb begin
        pre_last  = (pre_cnt == half - HALF_W'(1));
        phase_end = run && pre_last && (rate_cnt == rate);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_cnt  <= '0;
            rate_cnt <= '0;
        end else if (!run || phase_end) begin
            pre_cnt  <= '0;
            rate_cnt <= '0;
        end else if (pre_last) begin
            pre_cnt  <= '0;
            rate_cnt <= rate_cnt + RATE_W'(1);
        end else begin
            pre_cnt  <= pre_cnt + HALF_W'(1);
        end
    end

    a_r2_prescale_bound: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (pre_cnt < half));

    a_r2_rate_bound: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (rate_cnt <= rate));

endmodule

// File: rtl/card_clk_divider.sv
module card_clk_divider
    import card_clk_pkg::*;
#(
    parameter int DIV_W  = 8,
    parameter int RATE_W = 8,
    parameter int TMO_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [DIV_W-1:0]  cfg_divide,
    input  logic [RATE_W-1:0] cfg_rate,
    input  logic [TMO_W-1:0]  cfg_timeout,
    input  logic              run_req,
    input  logic              cont_clk_en,
    output logic              sclk_o,
    output logic              rise_stb_o,
    output logic              fall_stb_o,
    output logic [TMO_W-1:0]  tmo_limit_o
);

    localparam int HALF_W = DIV_W - 1;

    ck_state_e         state, nxt;
    logic              go;
    logic              phase_end;
    logic              load;
    logic [HALF_W-1:0] act_half;
    logic [RATE_W-1:0] act_rate;

    assign go   = run_req || cont_clk_en;
    assign load = (state == CK_IDLE) || ((state == CK_HIGH) && phase_end);

    clkdiv_cfg #(.DIV_W(DIV_W), .RATE_W(RATE_W), .TMO_W(TMO_W)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (cfg_we),
        .wr_div    (cfg_divide),
        .wr_rate   (cfg_rate),
        .wr_tmo    (cfg_timeout),
        .load      (load),
        .act_half  (act_half),
        .act_rate  (act_rate),
        .tmo_limit (tmo_limit_o)
    );

    clkdiv_phase #(.HALF_W(HALF_W), .RATE_W(RATE_W)) u_phase (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (state != CK_IDLE),
        .half      (act_half),
        .rate      (act_rate),
        .phase_end (phase_end)
    );

    always_comb begin
        nxt = state;
        unique case (state)
            CK_IDLE: if (go)        nxt = CK_HIGH;
            CK_HIGH: if (phase_end) nxt = CK_LOW;
            CK_LOW:  if (phase_end) nxt = go ? CK_HIGH : CK_IDLE;
            default:                nxt = CK_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= CK_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_o     <= 1'b0;
            rise_stb_o <= 1'b0;
            fall_stb_o <= 1'b0;
        end else begin
            sclk_o     <= (nxt == CK_HIGH);
            rise_stb_o <= (nxt == CK_HIGH) && (state != CK_HIGH);
            fall_stb_o <= (state == CK_HIGH) && (nxt != CK_HIGH);
        end
    end

    a_r10_rise_marks_edge: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sclk_o) |-> rise_stb_o);

    a_r10_fall_marks_edge: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sclk_o) |-> fall_stb_o);

    a_r10_rise_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        rise_stb_o |=> !rise_stb_o);

    a_r6_idle_held_low: assert property (@(posedge clk) disable iff (!rst_n)
        (state == CK_IDLE && !go) |=> (!sclk_o && !rise_stb_o));

    a_r9_divisor_frozen_high: assert property (@(posedge clk) disable iff (!rst_n)
        (state == CK_HIGH && $past(state) == CK_HIGH) |-> ($stable(act_half) && $stable(act_rate)));

endmodule

// File: tb/card_clk_divider_test.sv
`timescale 1ns/1ps
module card_clk_divider_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [7:0]  cfg_divide = 8'd2;
    logic [7:0]  cfg_rate = 8'd0;
    logic [15:0] cfg_timeout = 16'hFFFF;
    logic        run_req = 1'b0;
    logic        cont_clk_en = 1'b0;
    logic        sclk, rise_stb, fall_stb;
    logic [15:0] tmo;

    int checks = 0;
    int failures = 0;

    always #2.5 clk = ~clk;

    card_clk_divider uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_divide(cfg_divide),
        .cfg_rate(cfg_rate), .cfg_timeout(cfg_timeout), .run_req(run_req),
        .cont_clk_en(cont_clk_en), .sclk_o(sclk), .rise_stb_o(rise_stb),
        .fall_stb_o(fall_stb), .tmo_limit_o(tmo)
    );

    // {divide, rate, expected half-period}
    localparam int NV = 9;
    localparam logic [31:0] VEC [NV] = '{
        {8'd2,   8'd0, 16'd1},    // R3 fastest
        {8'd4,   8'd0, 16'd2},    // R2
        {8'd2,   8'd3, 16'd4},    // R2
        {8'd6,   8'd2, 16'd9},    // R2
        {8'd3,   8'd1, 16'd2},    // R4 odd rounds down
        {8'd0,   8'd0, 16'd1},    // R4 zero -> 2
        {8'd1,   8'd2, 16'd3},    // R4 one -> 2
        {8'd255, 8'd0, 16'd127},  // R4 top odd
        {8'd10,  8'd9, 16'd50}    // R2
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic write_cfg(input logic [7:0] d, input logic [7:0] r, input logic [15:0] t);
        @(negedge clk);
        cfg_divide = d; cfg_rate = r; cfg_timeout = t; cfg_we = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic measure(output int hi, output int lo);
        while (!sclk) @(negedge clk);
        hi = 0;
        while (sclk) begin hi++; @(negedge clk); end
        lo = 0;
        while (!sclk) begin lo++; @(negedge clk); end
    endtask

    task automatic settle();
        run_req = 1'b0;
        cont_clk_en = 1'b0;
        repeat (300) @(negedge clk);
    endtask

    initial begin
        repeat (2000000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int hi, lo, rises, bad;
        logic prev;

        repeat (3) @(negedge clk);
        check(!sclk && !rise_stb && !fall_stb, "R1 outputs in reset", sclk, 0);
        check(tmo == 16'hFFFF, "R1 timeout reset", tmo, 16'hFFFF);
        rst_n = 1'b1;
        @(negedge clk);
        check(!sclk && tmo == 16'hFFFF, "R1 after reset", sclk, 0);

        // R6: no request, nothing moves
        bad = 0;
        repeat (50) begin
            @(negedge clk);
            if (sclk || rise_stb || fall_stb) bad++;
        end
        check(bad == 0, "R6 idle held low", bad, 0);

        // Table: phase lengths for each divisor pair
        for (int i = 0; i < NV; i++) begin
            write_cfg(VEC[i][31:24], VEC[i][23:16], 16'hFFFF);
            repeat (2) @(negedge clk);
            run_req = 1'b1;
            measure(hi, lo);
            check(hi == int'(VEC[i][15:0]), "R2 high phase", hi, int'(VEC[i][15:0]));
            check(lo == int'(VEC[i][15:0]), "R2 low phase", lo, int'(VEC[i][15:0]));
            settle();
        end

        // R7: first rise one cycle after request
        write_cfg(8'd4, 8'd0, 16'hFFFF);
        repeat (2) @(negedge clk);
        run_req = 1'b1;
        @(negedge clk);
        check(sclk && rise_stb, "R7 first rise", {sclk, rise_stb}, 3);
        @(negedge clk);
        check(sclk && !rise_stb, "R10 rise single cycle", {sclk, rise_stb}, 2);
        settle();

        // R8: drop request mid-high
        write_cfg(8'd2, 8'd4, 16'hFFFF);
        repeat (2) @(negedge clk);
        run_req = 1'b1;
        while (!sclk) @(negedge clk);
        hi = 0;
        while (sclk) begin
            hi++;
            if (hi == 2) run_req = 1'b0;
            @(negedge clk);
        end
        check(hi == 5, "R8 high not shortened", hi, 5);
        rises = 0;
        repeat (60) begin
            if (sclk) rises++;
            @(negedge clk);
        end
        check(rises == 0, "R8 stays low after stop", rises, 0);
        settle();

        // R9: divisor written during high phase
        write_cfg(8'd2, 8'd1, 16'hFFFF);
        repeat (2) @(negedge clk);
        run_req = 1'b1;
        while (!sclk) @(negedge clk);
        cfg_divide = 8'd8; cfg_rate = 8'd0; cfg_we = 1'b1;
        hi = 1;
        @(negedge clk);
        cfg_we = 1'b0;
        while (sclk) begin hi++; @(negedge clk); end
        check(hi == 2, "R9 current high keeps old length", hi, 2);
        lo = 0;
        while (!sclk) begin lo++; @(negedge clk); end
        check(lo == 4, "R9 next low uses new divisor", lo, 4);
        hi = 0;
        while (sclk) begin hi++; @(negedge clk); end
        check(hi == 4, "R9 following high uses new divisor", hi, 4);
        settle();

        // R5 and R10: free-running mode with strobe consistency
        write_cfg(8'd2, 8'd0, 16'hFFFF);
        repeat (2) @(negedge clk);
        prev = sclk;
        cont_clk_en = 1'b1;
        rises = 0;
        bad = 0;
        repeat (160) begin
            @(negedge clk);
            if (rise_stb) rises++;
            if (rise_stb != (sclk && !prev)) bad++;
            if (fall_stb != (!sclk && prev)) bad++;
            prev = sclk;
        end
        check(rises >= 74, "R5 free-running rises", rises, 74);
        check(bad == 0, "R10 strobes match edges", bad, 0);

        // R11: timeout written while clock runs
        write_cfg(8'd2, 8'd0, 16'h0A5C);
        check(tmo == 16'h0A5C, "R11 timeout stored", tmo, 16'h0A5C);
        settle();
        check(tmo == 16'h0A5C && !sclk, "R11 timeout held when idle", tmo, 16'h0A5C);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule